// File: doc/BRIEF.md
# Driver Fault-Status and Output-Enable Core

This block is the digital heart of a multi-channel power driver that a host controller reaches over a serial peripheral interface. Each exchange is a 24-bit frame sent MSB first in SPI mode 0 (data sampled on the rising serial clock, shifted out on the falling one) with an active-low chip select. The host writes a control word while the block returns a status word. The status word is captured at the moment chip select falls.

The control word carries five settings:
- an enable that moves the block between standby and active;
- a one-shot command that clears the status;
- an overcurrent-recovery duty selection, which is passed straight out;
- a switch that chooses between automatic and host-acknowledged recovery after a supply fault;
- a two-bit current-monitor channel select.

The status word reports the following:
- latched overvoltage, undervoltage, thermal-shutdown and temperature-warning events;
- a not-ready flag that covers the charge-pump settling time after each wake-up;
- a fixed marker bit, so that a stuck-low or stuck-high link never looks like a valid reply.

From all of this the block drives a single global output enable.

The serial pins, the fault flags and the block's logic all run in the same clock domain. Any synchronization of the pins is done upstream.

Top module: `drv_ctl_core`

## Requirements
- R1: After reset the block is in standby: `out_en` is 0, `cm_chan` is 6 and `ocr_duty` is 0.
- R2: The reply frame is the status captured when `cs_n` falls, shifted out MSB first. Bit 23 always reads 1. Bit 22 is overvoltage, bit 21 undervoltage, bit 20 thermal shutdown, bit 19 temperature warning and bit 18 not-ready. Bits 17..0 read 0.
- R3: A control word is taken on the rising edge of `cs_n` only if exactly 24 rising serial-clock edges were seen while `cs_n` was low. A frame of any other length leaves every output and setting unchanged.
- R4: Writing control bit 23 (enable) as 0 puts the block in standby. In standby every control setting and status bit is cleared, `out_en` is 0, and fault flags are not latched.
- R5: A write that moves control bit 23 from 0 to 1 sets not-ready (status bit 18) for `STARTUP_CYC` clock cycles, after which it clears itself. `out_en` stays 0 while not-ready is set.
- R6: While `ov_flag` or `uv_flag` is high, `out_en` is 0 and the matching status bit is latched. With control bit 20 at 0, `out_en` returns as soon as both flags are low.
- R7: With control bit 20 (recovery disable) at 1, a latched overvoltage or undervoltage keeps `out_en` at 0 until the status is cleared.
- R8: A `tsd_flag` pulse latches status bit 20 and holds `out_en` at 0 until the status is cleared.
- R9: A `tw_flag` pulse latches status bit 19 without affecting `out_en`. The bit stays set until the status is cleared.
- R10: A committed word with control bit 22 set clears all latched status at the `cs_n` rising edge. The bit itself is not stored: the other settings are taken from the same word and `out_en` is unaffected except through the cleared faults.
- R11: Control bits 19:18 map to `cm_chan` as follows: 00 gives 6, 10 gives 1, 01 gives 4 and 11 gives 5.
- R12: `ocr_duty` follows control bit 21 of the last committed active word (0 selects the lower duty, 1 the higher).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk | input | 1 | Serial clock, already synchronous to `clk` |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial control data in |
| miso | output | 1 | Serial status data out, 0 while deselected |
| ov_flag | input | 1 | Supply overvoltage present |
| uv_flag | input | 1 | Supply undervoltage present |
| tsd_flag | input | 1 | Thermal shutdown event |
| tw_flag | input | 1 | Temperature warning event |
| out_en | output | 1 | Global output enable for the power stages |
| ocr_duty | output | 1 | Overcurrent recovery duty selection |
| cm_chan | output | 3 | Output number routed to the current monitor |

## Verification
The frame path is exercised in several ways:
- full 24-bit frames carry words that enable, clear and drop to standby;
- a 16-bit frame shows that a length error commits nothing;
- all four monitor-select codes are written, which separates the channel mapping from a plain pass-through.

Each fault type is pulsed or held in its own sequence, which tells apart three behaviours:
- self-recovering supply faults;
- host-acknowledged supply faults;
- sticky thermal faults and the warning that leaves the outputs alone.

Fault pulses applied during standby confirm that nothing latches there. Two consecutive reads after each event separate the reply captured before a clear from the one captured after it.

// File: rtl/drv_ctl_pkg.sv
package drv_ctl_pkg;

  localparam int FRAME_W = 24;
  localparam int CTL_W   = 6;            // control field is the top CTL_W bits

  // positions inside the captured control field (frame bits 23..18)
  localparam int K_EN   = 5;
  localparam int K_RST  = 4;
  localparam int K_DUTY = 3;
  localparam int K_RDIS = 2;
  localparam int K_CM1  = 1;
  localparam int K_CM0  = 0;

  // status frame positions
  localparam int S_MARK = 23;
  localparam int S_OV   = 22;
  localparam int S_UV   = 21;
  localparam int S_TSD  = 20;
  localparam int S_TW   = 19;
  localparam int S_NR   = 18;

  // latched fault vector indices
  localparam int N_FAULT = 4;
  localparam int F_OV    = 0;
  localparam int F_UV    = 1;
  localparam int F_TSD   = 2;
  localparam int F_TW    = 3;

  typedef struct packed {
    logic       en;
    logic       duty;
    logic       rdis;
    logic [1:0] cm;
  } ctrl_t;

  function automatic logic [2:0] cm_to_chan(input logic [1:0] code);
    logic [2:0] ch;
    case (code)
      2'b00:   ch = 3'd6;
      2'b10:   ch = 3'd1;
      2'b01:   ch = 3'd4;
      default: ch = 3'd5;
    endcase
    return ch;
  endfunction

endpackage

// File: rtl/spi_frame_port.sv
module spi_frame_port
  import drv_ctl_pkg::*;
#(
  parameter int W     = FRAME_W,
  parameter int CAP_W = CTL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             mosi,
  input  logic [W-1:0]     tx_word,
  output logic             miso,
  output logic [CAP_W-1:0] rx_top,
  output logic             rx_valid
);

  localparam int CNT_W = $clog2(W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);

  logic             sclk_q, cs_q;
  logic [W-1:0]     tx_q, tx_d;
  logic [W-1:0]     rx_q, rx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cs_fall, cs_rise, sck_rise, sck_fall;

  assign cs_fall  = cs_q & ~cs_n;
  assign cs_rise  = ~cs_q & cs_n;
  assign sck_rise = ~cs_n & sclk & ~sclk_q;
  assign sck_fall = ~cs_n & ~sclk & sclk_q;

  always_comb begin
    rx_d  = rx_q;
    tx_d  = tx_q;
    cnt_d = cnt_q;
    if (cs_fall) begin
      tx_d  = tx_word;
      cnt_d = '0;
    end else begin
      if (sck_fall) tx_d = {tx_q[W-2:0], 1'b0};
      if (sck_rise) begin
        rx_d = {rx_q[W-2:0], mosi};
        if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      tx_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      cnt_q  <= cnt_d;
    end
  end

  assign miso     = ~cs_q & tx_q[W-1];
  assign rx_top   = rx_q[W-1 -: CAP_W];
  assign rx_valid = cs_rise & (cnt_q == CNT_FULL);

endmodule

// File: rtl/startup_timer.sv
module startup_timer #(
  parameter int STARTUP_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy
);

  localparam int CW = (STARTUP_CYC > 1) ? $clog2(STARTUP_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(STARTUP_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (abort) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/ctl_status_regs.sv
module ctl_status_regs
  import drv_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [CTL_W-1:0]   wr_bits,
  input  logic [N_FAULT-1:0] flags,
  output ctrl_t              ctrl,
  output logic [N_FAULT-1:0] faults,
  output logic               wake,
  output logic               sleep
);

  ctrl_t              ctrl_q, ctrl_d;
  logic [N_FAULT-1:0] fault_q, fault_d;
  logic               clr, set_en;

  assign sleep  = commit & ~wr_bits[K_EN];
  assign wake   = commit & wr_bits[K_EN] & ~ctrl_q.en;
  assign clr    = sleep | (commit & wr_bits[K_RST]);
  assign set_en = ctrl_q.en & ~sleep;

  always_comb begin
    ctrl_d = ctrl_q;
    if (commit) begin
      if (wr_bits[K_EN]) begin
        ctrl_d.en   = 1'b1;
        ctrl_d.duty = wr_bits[K_DUTY];
        ctrl_d.rdis = wr_bits[K_RDIS];
        ctrl_d.cm   = {wr_bits[K_CM1], wr_bits[K_CM0]};
      end else begin
        ctrl_d = '0;
      end
    end
  end

  // a fault present in the clearing cycle survives the clear
  for (genvar g = 0; g < N_FAULT; g++) begin : g_latch
    assign fault_d[g] = (clr ? 1'b0 : fault_q[g]) | (set_en & flags[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      fault_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      fault_q <= fault_d;
    end
  end

  assign ctrl   = ctrl_q;
  assign faults = fault_q;

endmodule

// File: rtl/drv_ctl_core.sv
module drv_ctl_core
  import drv_ctl_pkg::*;
#(
  parameter int STARTUP_CYC = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       miso,
  input  logic       ov_flag,
  input  logic       uv_flag,
  input  logic       tsd_flag,
  input  logic       tw_flag,
  output logic       out_en,
  output logic       ocr_duty,
  output logic [2:0] cm_chan
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ni = rst_pipe[SYNC_STAGES-1];

  logic [FRAME_W-1:0] stat_word;
  logic [CTL_W-1:0]   rx_bits;
  logic               rx_valid;
  ctrl_t              ctrl;
  logic [N_FAULT-1:0] flags, faults;
  logic               wake, sleep, nr;
  logic               sup_now, sup_held;

  assign flags[F_OV]  = ov_flag;
  assign flags[F_UV]  = uv_flag;
  assign flags[F_TSD] = tsd_flag;
  assign flags[F_TW]  = tw_flag;

  always_comb begin
    stat_word         = '0;
    stat_word[S_MARK] = 1'b1;
    stat_word[S_OV]   = faults[F_OV];
    stat_word[S_UV]   = faults[F_UV];
    stat_word[S_TSD]  = faults[F_TSD];
    stat_word[S_TW]   = faults[F_TW];
    stat_word[S_NR]   = nr;
  end

  spi_frame_port #(.W(FRAME_W), .CAP_W(CTL_W)) u_port (
    .clk      (clk),
    .rst_n    (rst_ni),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .mosi     (mosi),
    .tx_word  (stat_word),
    .miso     (miso),
    .rx_top   (rx_bits),
    .rx_valid (rx_valid)
  );

  ctl_status_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_ni),
    .commit  (rx_valid),
    .wr_bits (rx_bits),
    .flags   (flags),
    .ctrl    (ctrl),
    .faults  (faults),
    .wake    (wake),
    .sleep   (sleep)
  );

  startup_timer #(.STARTUP_CYC(STARTUP_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_ni),
    .start (wake),
    .abort (sleep),
    .busy  (nr)
  );

  assign sup_now  = ov_flag | uv_flag;
  assign sup_held = ctrl.rdis & (faults[F_OV] | faults[F_UV]);
  assign out_en   = ctrl.en & ~nr & ~faults[F_TSD] & ~sup_now & ~sup_held;
  assign ocr_duty = ctrl.duty;
  assign cm_chan  = cm_to_chan(ctrl.cm);

endmodule

// File: rtl/drv_ctl_checker.sv
module drv_ctl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       miso,
  input logic       out_en,
  input logic       en,
  input logic       rdis,
  input logic       nr,
  input logic       ov_flag,
  input logic       uv_flag,
  input logic       tsd_flag,
  input logic [2:0] cm_chan
);

  p_marker_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |=> miso);

  p_notready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nr |-> !out_en);

  p_notready_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nr) |=> nr);

  p_standby_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!out_en && cm_chan == 3'd6));

  p_supply_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_flag || uv_flag) |-> !out_en);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdis && en && (ov_flag || uv_flag)) |=> !out_en);

  p_tsd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_flag |=> !out_en);

  p_chan_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cm_chan inside {3'd1, 3'd4, 3'd5, 3'd6});

endmodule

bind drv_ctl_core drv_ctl_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_ni),
  .cs_n     (cs_n),
  .miso     (miso),
  .out_en   (out_en),
  .en       (ctrl.en),
  .rdis     (ctrl.rdis),
  .nr       (nr),
  .ov_flag  (ov_flag),
  .uv_flag  (uv_flag),
  .tsd_flag (tsd_flag),
  .cm_chan  (cm_chan)
);

// File: tb/sim_drv_ctl_core.sv
`timescale 1ns/1ps
module sim_drv_ctl_core;

  localparam int STARTUP = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       mosi = 1'b0;
  logic       ov_flag = 1'b0, uv_flag = 1'b0, tsd_flag = 1'b0, tw_flag = 1'b0;
  logic       miso, out_en, ocr_duty;
  logic [2:0] cm_chan;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [23:0] exp_q[$];
  string       tag_q[$];
  logic [23:0] mon_sh = '0;
  int          mon_cnt = 0;

  always #10 clk = ~clk;

  drv_ctl_core #(.STARTUP_CYC(STARTUP)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .ov_flag(ov_flag), .uv_flag(uv_flag), .tsd_flag(tsd_flag),
    .tw_flag(tw_flag), .out_en(out_en), .ocr_duty(ocr_duty), .cm_chan(cm_chan)
  );

  task automatic check(input bit ok, input string tag, input logic [23:0] act,
                       input logic [23:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: collect reply bits, compare whole frames against the queue
  always @(negedge cs_n) mon_cnt = 0;
  always @(posedge sclk) if (!cs_n) begin
    mon_sh = {mon_sh[22:0], miso};
    mon_cnt++;
  end
  always @(posedge cs_n) if (mon_cnt == 24) begin
    if (exp_q.size() == 0) check(1'b0, "R2 unexpected frame", mon_sh, '0);
    else begin
      logic [23:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(mon_sh == e, t, mon_sh, e);
    end
  end

  // driver: one frame, pushing the expected reply first
  task automatic xfer(input logic [23:0] w, input int nbits,
                      input logic [23:0] exp, input string tag);
    if (nbits == 24) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = w[23-i];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_out(input logic e_en, input logic [2:0] e_ch,
                         input logic e_duty, input string tag);
    check({out_en, cm_chan, ocr_duty} == {e_en, e_ch, e_duty}, tag,
          24'({out_en, cm_chan, ocr_duty}), 24'({e_en, e_ch, e_duty}));
  endtask

  task automatic pulse(ref logic f, input int n);
    @(negedge clk) f = 1'b1;
    repeat (n) @(negedge clk);
    f = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", '0, '0);
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_out(1'b0, 3'd6, 1'b0, "R1 reset state");

    xfer(24'h000000, 24, 24'h800000, "R2 marker in standby reply");
    xfer(24'hA80000, 24, 24'h800000, "R2 reply before enable");
    chk_out(1'b0, 3'd1, 1'b1, "R5 out_en low right after wake, R11 code 10, R12 duty");
    xfer(24'hA80000, 24, 24'h840000, "R5 not-ready bit18 set after wake");
    chk_out(1'b1, 3'd1, 1'b1, "R5 out_en after startup time");

    xfer(24'h000000, 16, 24'h0, "R3 short frame");
    chk_out(1'b1, 3'd1, 1'b1, "R3 short frame commits nothing");

    pulse(tw_flag, 1);
    chk_out(1'b1, 3'd1, 1'b1, "R9 warning leaves outputs on");
    xfer(24'hA80000, 24, 24'h880000, "R9 warning latched bit19");
    xfer(24'hE80000, 24, 24'h880000, "R9 warning still latched");
    chk_out(1'b1, 3'd1, 1'b1, "R10 clear word keeps settings");
    xfer(24'hA80000, 24, 24'h800000, "R10 status cleared");

    @(negedge clk) ov_flag = 1'b1;
    repeat (2) @(negedge clk);
    chk_out(1'b0, 3'd1, 1'b1, "R6 out_en off during overvoltage");
    ov_flag = 1'b0;
    repeat (2) @(negedge clk);
    chk_out(1'b1, 3'd1, 1'b1, "R6 auto recovery");
    xfer(24'hE80000, 24, 24'hC00000, "R6 overvoltage latched bit22");

    xfer(24'hB80000, 24, 24'h800000, "R10 clear before recovery-disable");
    pulse(uv_flag, 3);
    chk_out(1'b0, 3'd1, 1'b1, "R7 held off after undervoltage");
    xfer(24'hB80000, 24, 24'hA00000, "R7 undervoltage latched bit21");
    chk_out(1'b0, 3'd1, 1'b1, "R7 still held off");
    xfer(24'hF80000, 24, 24'hA00000, "R7 reply before clear");
    chk_out(1'b1, 3'd1, 1'b1, "R7 released by clear");

    pulse(tsd_flag, 1);
    chk_out(1'b0, 3'd1, 1'b1, "R8 thermal shutdown off");
    xfer(24'hA80000, 24, 24'h900000, "R8 thermal latched bit20");
    chk_out(1'b0, 3'd1, 1'b1, "R8 stays off");
    xfer(24'hE80000, 24, 24'h900000, "R8 reply before clear");
    chk_out(1'b1, 3'd1, 1'b1, "R8 released by clear");

    xfer(24'h840000, 24, 24'h800000, "R10 status clean");
    chk_out(1'b1, 3'd4, 1'b0, "R11 code 01, R12 duty low");
    xfer(24'h8C0000, 24, 24'h800000, "R11 reply");
    chk_out(1'b1, 3'd5, 1'b0, "R11 code 11");
    xfer(24'h800000, 24, 24'h800000, "R11 reply");
    chk_out(1'b1, 3'd6, 1'b0, "R11 code 00");

    xfer(24'h380000, 24, 24'h800000, "R4 reply before standby");
    chk_out(1'b0, 3'd6, 1'b0, "R4 standby clears settings");
    pulse(tw_flag, 1);
    pulse(tsd_flag, 1);
    xfer(24'h000000, 24, 24'h800000, "R4 faults ignored in standby");
    xfer(24'h800000, 24, 24'h800000, "R4 reply still clean");
    chk_out(1'b0, 3'd6, 1'b0, "R5 off right after re-wake");
    xfer(24'h800000, 24, 24'h840000, "R5 not-ready after re-wake");
    chk_out(1'b1, 3'd6, 1'b0, "R5 on after startup");

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R2 all replies seen", 24'(exp_q.size()), 24'd0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule